// File: doc/BRIEF.md
# Modem Line Control and Status Unit

This unit sits behind the register decoder of a 16450-style serial controller and owns its modem handshake lines. Software writes a control byte that drives four modem output lines: data-terminal-ready, request-to-send and two general-purpose outputs. It also reads a status byte that reports the level of the four modem input lines: clear-to-send, data-set-ready, ring indicator and carrier detect. The status byte also holds four sticky change flags. The input lines are double-flopped before any comparison is made. Each flag is set when its line changes. For the ring line, the flag is set only on the trailing (1-to-0) edge. A status read clears all four flags. While any flag is set and the external enable bit is high, a single interrupt request is raised.

A two-state mode machine selects where the status levels come from. In state MODE_PINS the levels come from the synchronized input pins, and the output lines follow the control bits. In state MODE_LOOP the output lines are forced low, and the control bits are fed back into the status levels through a fixed cross-mapping. This allows software to test the status path without external wiring. The machine has two transitions, both taken on a control write. WR_LOOP_ON (a write with bit 4 set) moves from MODE_PINS to MODE_LOOP. WR_LOOP_OFF (a write with bit 4 clear) moves from MODE_LOOP to MODE_PINS. A write that does not change bit 4 keeps the current state.

Top module: `modem_ctl_status`

## Requirements
- R1: After reset the status byte reads 0xB0 (carrier, data-set-ready and clear-to-send set, ring clear, no flags), the control readback is 0x00, all output lines are low, irq_req is low and irq_ident is 0x1.
- R2: A control write stores ctl_wdata[4:0]; ctl_rdata returns them with bits 7:5 zero from the cycle after the write edge. In MODE_PINS, modem_dtr = bit 0, modem_rts = bit 1, modem_aux1 = bit 2 and modem_aux2 = bit 3.
- R3: In MODE_PINS the status bits report line levels: carrier at bit 7, ring at bit 6, data-set-ready at bit 5 and clear-to-send at bit 4. A pin change appears after the third rising edge and not before it.
- R4: Any change of clear-to-send, data-set-ready or carrier sets its flag: bit 0, bit 1 or bit 3 respectively.
- R5: The ring flag (bit 2) is set by a 1-to-0 change of the ring level only; a 0-to-1 change leaves it clear.
- R6: A status read (sts_rd high at an edge) clears all four flags at that edge.
- R7: A change detected at the same edge as a status read leaves its flag set, while the other flags clear.
- R8: irq_req is high exactly when a flag is set and msi_en is high. irq_ident is 0x0 while irq_req is high, and 0x1 otherwise.
- R9: In MODE_LOOP the status levels come from the control bits: bit 3 to status 7, bit 2 to status 6, bit 0 to status 5 and bit 1 to status 4. The input pins are ignored.
- R10: In MODE_LOOP all four output lines are driven low, whatever the control bits hold.
- R11: A WR_LOOP_OFF write returns the status levels to the synchronized pins, and the output lines to the control bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte readback |
| sts_rd | input | 1 | Status read strobe (clears flags) |
| sts_rdata | output | 8 | Status byte |
| msi_en | input | 1 | Modem-status interrupt enable |
| modem_cts | input | 1 | Clear-to-send input line |
| modem_dsr | input | 1 | Data-set-ready input line |
| modem_ri | input | 1 | Ring indicator input line |
| modem_dcd | input | 1 | Carrier detect input line |
| modem_dtr | output | 1 | Data-terminal-ready output line |
| modem_rts | output | 1 | Request-to-send output line |
| modem_aux1 | output | 1 | General-purpose output line 1 |
| modem_aux2 | output | 1 | General-purpose output line 2 |
| irq_req | output | 1 | Modem-status interrupt request |
| irq_ident | output | 4 | Interrupt identification: 0x0 pending, 0x1 none |

## Verification
The two functions that can fall in one cycle are flag detection and the clearing status read. The bench sets one flag in advance. It then changes a second line and times sts_rd so that the read lands on the exact edge where the synchronized change reaches the comparator. Afterwards the earlier flag must be gone and the new one must remain. A mode change that moves the level source at the same edge is also covered: entering or leaving MODE_LOOP must raise the flags for the lines whose level differs between the two sources.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
    localparam int LINES     = 4;
    localparam int CTL_BITS  = 5;
    // line index inside a nibble: level at index+4, flag at index
    localparam int LN_CTS = 0;
    localparam int LN_DSR = 1;
    localparam int LN_RI  = 2;
    localparam int LN_DCD = 3;
    // control bit positions
    localparam int CB_DTR  = 0;
    localparam int CB_RTS  = 1;
    localparam int CB_AUX1 = 2;
    localparam int CB_AUX2 = 3;
    localparam int CB_LOOP = 4;
    localparam logic [LINES-1:0] LVL_RESET = 4'b1011;

    typedef enum logic {
        MODE_PINS = 1'b0,
        MODE_LOOP = 1'b1
    } mode_t;
endpackage

// File: rtl/mcs_sync.sv
module mcs_sync #(
    parameter int W = 4,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
        end else begin
            stg[0] <= din;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/mcs_mode.sv
module mcs_mode
    import mcs_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_wr,
    input  logic [CTL_BITS-1:0] ctl_wdata,
    output logic [CTL_BITS-1:0] ctl_q,
    output logic                loop_on,
    output logic [LINES-1:0]    pin_out,
    output logic [LINES-1:0]    loop_lvl
);
    mode_t state, state_nx;

    // next-state: WR_LOOP_ON / WR_LOOP_OFF
    always_comb begin
        state_nx = state;
        unique case (state)
            MODE_PINS: if (ctl_wr && ctl_wdata[CB_LOOP])  state_nx = MODE_LOOP;
            MODE_LOOP: if (ctl_wr && !ctl_wdata[CB_LOOP]) state_nx = MODE_PINS;
            default:   state_nx = MODE_PINS;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= MODE_PINS;
            ctl_q <= '0;
        end else begin
            state <= state_nx;
            if (ctl_wr) ctl_q <= ctl_wdata;
        end
    end

    // outputs
    always_comb begin
        pin_out  = '0;
        loop_lvl = '0;
        loop_on  = 1'b0;
        unique case (state)
            MODE_PINS: begin
                pin_out = {ctl_q[CB_AUX2], ctl_q[CB_AUX1], ctl_q[CB_RTS], ctl_q[CB_DTR]};
            end
            MODE_LOOP: begin
                loop_on          = 1'b1;
                loop_lvl[LN_DCD] = ctl_q[CB_AUX2];
                loop_lvl[LN_RI]  = ctl_q[CB_AUX1];
                loop_lvl[LN_DSR] = ctl_q[CB_DTR];
                loop_lvl[LN_CTS] = ctl_q[CB_RTS];
            end
            default: ;
        endcase
    end

    p_ctl_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> ctl_q == $past(ctl_wdata));
    p_mode_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> loop_on == $past(ctl_wdata[CB_LOOP]));
endmodule

// File: rtl/mcs_delta.sv
module mcs_delta
    import mcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] src,
    input  logic             rd_clr,
    input  logic             msi_en,
    output logic [LINES-1:0] lvl_q,
    output logic [LINES-1:0] delta_q,
    output logic             irq
);
    logic [LINES-1:0] det;

    for (genvar i = 0; i < LINES; i++) begin : g_det
        if (i == LN_RI) begin : g_trail
            assign det[i] = lvl_q[i] & ~src[i];
        end else begin : g_any
            assign det[i] = lvl_q[i] ^ src[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q   <= LVL_RESET;
            delta_q <= '0;
        end else begin
            lvl_q   <= src;
            delta_q <= (rd_clr ? '0 : delta_q) | det;
        end
    end

    assign irq = msi_en & (|delta_q);

    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_clr) |-> (($past(delta_q) & ~delta_q) == '0));
    p_ri_trailing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(delta_q[LN_RI]) |-> ($past(lvl_q[LN_RI]) && !lvl_q[LN_RI]));
    p_cts_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(delta_q[LN_CTS]) |-> (lvl_q[LN_CTS] != $past(lvl_q[LN_CTS])));
endmodule

// File: rtl/modem_ctl_status.sv
module modem_ctl_status
    import mcs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_wdata,
    output logic [7:0] ctl_rdata,
    input  logic       sts_rd,
    output logic [7:0] sts_rdata,
    input  logic       msi_en,
    input  logic       modem_cts,
    input  logic       modem_dsr,
    input  logic       modem_ri,
    input  logic       modem_dcd,
    output logic       modem_dtr,
    output logic       modem_rts,
    output logic       modem_aux1,
    output logic       modem_aux2,
    output logic       irq_req,
    output logic [3:0] irq_ident
);
    logic [CTL_BITS-1:0] ctl_q;
    logic                loop_on;
    logic [LINES-1:0]    pin_out, loop_lvl, pin_sync, src, lvl_q, delta_q;
    logic                unused_wr_hi;

    assign unused_wr_hi = ^ctl_wdata[7:CTL_BITS];

    mcs_sync #(.W(LINES), .STAGES(SYNC_STAGES), .RST_VAL(LVL_RESET)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({modem_dcd, modem_ri, modem_dsr, modem_cts}),
        .dout (pin_sync)
    );

    mcs_mode u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (ctl_wr),
        .ctl_wdata(ctl_wdata[CTL_BITS-1:0]),
        .ctl_q    (ctl_q),
        .loop_on  (loop_on),
        .pin_out  (pin_out),
        .loop_lvl (loop_lvl)
    );

    assign src = loop_on ? loop_lvl : pin_sync;

    mcs_delta u_delta (
        .clk    (clk),
        .rst_n  (rst_n),
        .src    (src),
        .rd_clr (sts_rd),
        .msi_en (msi_en),
        .lvl_q  (lvl_q),
        .delta_q(delta_q),
        .irq    (irq_req)
    );

    assign sts_rdata  = {lvl_q, delta_q};
    assign ctl_rdata  = {{(8-CTL_BITS){1'b0}}, ctl_q};
    assign modem_dtr  = pin_out[0];
    assign modem_rts  = pin_out[1];
    assign modem_aux1 = pin_out[2];
    assign modem_aux2 = pin_out[3];
    assign irq_ident  = irq_req ? 4'h0 : 4'h1;

    p_loop_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[CB_LOOP] |-> !(modem_dtr | modem_rts | modem_aux1 | modem_aux2));
    p_irq_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (msi_en && sts_rdata[3:0] != 4'h0));
endmodule

// File: tb/modem_ctl_status_tb.sv
module modem_ctl_status_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0;
    logic ctl_wr = 0, sts_rd = 0, msi_en = 0;
    logic [7:0] ctl_wdata = 0;
    logic cts = 1, dsr = 1, ri = 0, dcd = 1;
    logic [7:0] ctl_rdata, sts_rdata;
    logic dtr, rts, aux1, aux2, irq_req;
    logic [3:0] irq_ident;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    modem_ctl_status u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .sts_rd(sts_rd), .sts_rdata(sts_rdata),
        .msi_en(msi_en), .modem_cts(cts), .modem_dsr(dsr), .modem_ri(ri),
        .modem_dcd(dcd), .modem_dtr(dtr), .modem_rts(rts), .modem_aux1(aux1),
        .modem_aux2(aux2), .irq_req(irq_req), .irq_ident(irq_ident)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        ctl_wr = 1; ctl_wdata = v;
        @(negedge clk);
        ctl_wr = 0;
    endtask

    task automatic rd_sts();
        sts_rd = 1;
        @(negedge clk);
        sts_rd = 0;
    endtask

    task automatic t_reset();
        chk("R1 status", sts_rdata, 8'hB0);
        chk("R1 ctl", ctl_rdata, 8'h00);
        chk("R1 pins", {aux2, aux1, rts, dtr}, 4'h0);
        chk("R1 irq", {irq_req, irq_ident}, 5'h01);
    endtask

    task automatic t_ctl();
        wr_ctl(8'hEF);
        chk("R2 readback", ctl_rdata, 8'h0F);
        chk("R2 pins all", {aux2, aux1, rts, dtr}, 4'hF);
        wr_ctl(8'h05);
        chk("R2 pins mix", {aux2, aux1, rts, dtr}, 4'h5);
    endtask

    task automatic t_levels();
        dsr = 0;
        step(2);
        chk("R3 not before 3rd edge", sts_rdata, 8'hB0);
        step(1);
        chk("R3 dsr level R4 flag", sts_rdata, 8'h92);
        rd_sts();
        chk("R6 clear", sts_rdata, 8'h90);
    endtask

    task automatic t_edges();
        cts = 0; step(3);
        chk("R4 cts fall", sts_rdata, 8'h81);
        rd_sts();
        cts = 1; step(3);
        chk("R4 cts rise", sts_rdata, 8'h91);
        dcd = 0; step(3);
        chk("R4 dcd fall", sts_rdata, 8'h19);
        rd_sts();
        chk("R6 clear all", sts_rdata, 8'h10);
    endtask

    task automatic t_ring();
        ri = 1; step(3);
        chk("R5 ri rise no flag", sts_rdata, 8'h50);
        ri = 0; step(3);
        chk("R5 ri fall flag", sts_rdata, 8'h14);
        rd_sts();
    endtask

    task automatic t_irq();
        msi_en = 1; step(1);
        chk("R8 no flag", {irq_req, irq_ident}, 5'h01);
        cts = 0; step(3);
        chk("R8 pending", {irq_req, irq_ident}, 5'h10);
        msi_en = 0; step(1);
        chk("R8 disabled", {irq_req, irq_ident}, 5'h01);
        msi_en = 1; rd_sts();
        chk("R8 cleared", {irq_req, irq_ident}, 5'h01);
    endtask

    task automatic t_same_cycle();
        dsr = 1; step(3);
        chk("R7 setup", sts_rdata, 8'h22);
        cts = 1; step(2);
        rd_sts();
        chk("R7 set beats clear", sts_rdata, 8'h31);
        rd_sts();
        chk("R6 after R7", sts_rdata, 8'h30);
    endtask

    task automatic t_loop();
        dcd = 1; step(3); rd_sts();
        chk("R9 setup", sts_rdata, 8'hB0);
        wr_ctl(8'h10);
        chk("R10 pins low", {aux2, aux1, rts, dtr}, 4'h0);
        chk("R9 ctl", ctl_rdata, 8'h10);
        step(1);
        chk("R9 loop zero", sts_rdata, 8'h0B);
        rd_sts();
        wr_ctl(8'h1F);
        chk("R10 pins low all set", {aux2, aux1, rts, dtr}, 4'h0);
        step(1);
        chk("R9 loop all", sts_rdata, 8'hFB);
        rd_sts();
        cts = 0; dsr = 0; step(4);
        chk("R9 pins ignored", sts_rdata, 8'hF0);
        wr_ctl(8'h1B); step(1);
        chk("R9 aux1 to ri fall", sts_rdata, 8'hB4);
        rd_sts();
        wr_ctl(8'h13); step(1);
        chk("R9 aux2 to dcd", sts_rdata, 8'h38);
        rd_sts();
        cts = 0; dsr = 1; dcd = 1; ri = 0; step(3);
        wr_ctl(8'h03);
        chk("R11 pins follow", {aux2, aux1, rts, dtr}, 4'h3);
        step(1);
        chk("R11 pin levels", sts_rdata, 8'hA9);
    endtask

    initial begin
        step(3);
        rst_n = 1;
        step(2);
        t_reset();
        t_ctl();
        t_levels();
        t_edges();
        t_ring();
        t_irq();
        t_same_cycle();
        t_loop();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule